// File: doc/BRIEF.md
# Instruction Byte Queue Controller

This block keeps track of a two-byte prefetch queue that hands opcode bytes, one at a time, to a microcoded processor. Each cycle the microcode may issue one of five commands: dispatch the next opcode, read a byte, write a freshly fetched 16-bit word, or re-align the queue after a jump by setting it to "one byte" or to "word". The controller holds a two-bit occupancy state. It decides whether a dispatch can proceed or must instead raise a refill trap, and it drives the strobes that move a byte into the front-byte register.

The datapath holds the last fetched word and the front-byte register. The even byte is the upper half of a word, bits [15:8]. The odd byte is the lower half, bits [7:0]. Occupancy states: EMPTY (code 0), ONE (code 1), FULL (code 2), WORD (code 3). Transitions: ADVANCE takes FULL→WORD→ONE→EMPTY, and EMPTY→EMPTY. FILL takes EMPTY→WORD, or EMPTY→ONE with the byte hint. TOP-UP takes any non-empty state→FULL. ALIGN-WORD goes to WORD and ALIGN-BYTE goes to ONE. HOLD leaves the state where it is.

Top module: `ibq_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the state is EMPTY (code 0), `empty_n` is 0, `front_byte` is 0, and no strobe, dispatch or trap is active.
- R2: `next_occ` encodes EMPTY=0, ONE=1, FULL=2, WORD=3, and the state takes that value at the next clock edge. With no command present the state holds.
- R3: A dispatch counts only when `dispatch_en` is 1 and none of read, write or set-word is present. If `irq_pending` is 1 or the state is not FULL, and set-byte is absent, it raises `refill_trap`. Otherwise it raises `dispatch_ok` and advances.
- R4: An advance moves FULL→WORD→ONE→EMPTY and leaves EMPTY at EMPTY. It pulses `front_wr`, and it drives `even_sel_n` low when bit 0 of the current state code is 0, or `odd_sel_n` low otherwise.
- R5: A read with no other command advances as in R4 and never raises a trap.
- R6: Read together with dispatch, or read together with write, is a no-op: no strobe, no trap, and the state holds.
- R7: A write (without dispatch or read) in EMPTY loads the front byte from the incoming word. With set-byte also present it selects the odd byte and goes to ONE. Otherwise it selects the even byte and goes to WORD.
- R8: A write in a non-empty state goes to FULL, stores the incoming word, and does not touch the front byte.
- R9: A lone set-word loads the front byte from the even byte of the stored word and goes to WORD. A lone set-byte loads it from the odd byte and goes to ONE. Both together are a no-op.
- R10: `empty_n` is active low and is 0 exactly when `next_occ` is EMPTY.
- R11: `trap_cause` is 3 for a pending interrupt, 2 for a refill with the queue not empty, and 1 for a refill with the queue empty. It is 0 whenever no trap is raised.
- R12: `front_byte` takes the selected byte at the edge that ends a cycle with `front_wr` high, and holds otherwise.
- R13: A dispatch with `dispatch_en` low is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dispatch_req | input | 1 | Dispatch next opcode |
| dispatch_en | input | 1 | Qualifier that enables dispatch |
| read_req | input | 1 | Read one byte |
| write_req | input | 1 | Write fetched word |
| set_byte_req | input | 1 | Align to one byte / byte hint |
| set_word_req | input | 1 | Align to word |
| irq_pending | input | 1 | Interrupt pending |
| fetch_word | input | WORD_W | Fetched word |
| dispatch_ok | output | 1 | Good dispatch |
| refill_trap | output | 1 | Trap instead of dispatch |
| trap_cause | output | 2 | Trap cause code |
| front_wr | output | 1 | Front-byte write strobe |
| even_sel_n | output | 1 | Even byte select, active low |
| odd_sel_n | output | 1 | Odd byte select, active low |
| empty_n | output | 1 | Next state empty, active low |
| next_occ | output | 2 | Next occupancy code |
| front_byte | output | WORD_W/2 | Front-byte register |

## Verification
A wrong state register shows at once, in the same cycle, on `next_occ`, on the byte selects and on the dispatch-or-trap choice, because all of them are computed from the current state. A stale or misrouted byte shows on `front_byte` one edge after the strobe. The bench therefore walks the queue through every state and compares every output in every cycle. This catches a bad transition in the cycle right after it happens.

// File: rtl/ibq_pkg.sv
`timescale 1ns/1ps
package ibq_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_FULL  = 2'd2,
        OCC_WORD  = 2'd3
    } occ_e;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_DISPATCH = 3'd1,
        OP_READ     = 3'd2,
        OP_WRITE    = 3'd3,
        OP_SET_WORD = 3'd4,
        OP_SET_BYTE = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE         = 2'd0,
        CAUSE_REFILL_EMPTY = 2'd1,
        CAUSE_REFILL_PART  = 2'd2,
        CAUSE_IRQ          = 2'd3
    } cause_e;
endpackage

// File: rtl/ibq_cmd_decode.sv
`timescale 1ns/1ps
module ibq_cmd_decode
    import ibq_pkg::*;
(
    input  logic dispatch_req,
    input  logic dispatch_en,
    input  logic read_req,
    input  logic write_req,
    input  logic set_byte_req,
    input  logic set_word_req,
    output op_e  op
);
    // Qualify the raw command lines into at most one operation.
    // Any illegal mix falls through to OP_NONE.
    always_comb begin
        op = OP_NONE;
        if (dispatch_req && dispatch_en && !read_req && !write_req && !set_word_req)
            op = OP_DISPATCH;
        else if (read_req && !dispatch_req && !write_req && !set_word_req && !set_byte_req)
            op = OP_READ;
        else if (write_req && !dispatch_req && !read_req)
            op = OP_WRITE;
        else if (set_word_req && !dispatch_req && !read_req && !write_req && !set_byte_req)
            op = OP_SET_WORD;
        else if (set_byte_req && !dispatch_req && !read_req && !write_req && !set_word_req)
            op = OP_SET_BYTE;
    end
endmodule

// File: rtl/ibq_occ_fsm.sv
`timescale 1ns/1ps
module ibq_occ_fsm
    import ibq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  op_e    op,
    input  logic   byte_hint,
    input  logic   irq_pending,
    output occ_e   occ_q,
    output occ_e   occ_nxt,
    output logic   dispatch_ok,
    output logic   refill_trap,
    output cause_e cause,
    output logic   front_wr,
    output logic   pick_even,
    output logic   pick_odd
);
    logic advance;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= OCC_EMPTY;
        else        occ_q <= occ_nxt;
    end

    // Next state and outputs
    always_comb begin
        occ_nxt     = occ_q;
        dispatch_ok = 1'b0;
        refill_trap = 1'b0;
        cause       = CAUSE_NONE;
        front_wr    = 1'b0;
        pick_even   = 1'b0;
        pick_odd    = 1'b0;
        advance     = 1'b0;

        unique case (op)
            OP_DISPATCH: begin
                if ((irq_pending || occ_q != OCC_FULL) && !byte_hint) begin
                    refill_trap = 1'b1;
                    if (irq_pending)             cause = CAUSE_IRQ;
                    else if (occ_q == OCC_EMPTY) cause = CAUSE_REFILL_EMPTY;
                    else                         cause = CAUSE_REFILL_PART;
                end else begin
                    dispatch_ok = 1'b1;
                    advance     = 1'b1;
                end
            end
            OP_READ: advance = 1'b1;
            OP_WRITE: begin
                if (occ_q == OCC_EMPTY) begin
                    front_wr = 1'b1;
                    if (byte_hint) begin
                        pick_odd = 1'b1;
                        occ_nxt  = OCC_ONE;
                    end else begin
                        pick_even = 1'b1;
                        occ_nxt   = OCC_WORD;
                    end
                end else begin
                    occ_nxt = OCC_FULL;
                end
            end
            OP_SET_WORD: begin
                front_wr  = 1'b1;
                pick_even = 1'b1;
                occ_nxt   = OCC_WORD;
            end
            OP_SET_BYTE: begin
                front_wr = 1'b1;
                pick_odd = 1'b1;
                occ_nxt  = OCC_ONE;
            end
            default: ;
        endcase

        if (advance) begin
            front_wr = 1'b1;
            unique case (occ_q)
                OCC_FULL:  begin pick_even = 1'b1; occ_nxt = OCC_WORD;  end
                OCC_WORD:  begin pick_odd  = 1'b1; occ_nxt = OCC_ONE;   end
                OCC_ONE:   begin pick_odd  = 1'b1; occ_nxt = OCC_EMPTY; end
                OCC_EMPTY: begin pick_even = 1'b1; occ_nxt = OCC_EMPTY; end
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/ibq_byte_path.sv
`timescale 1ns/1ps
module ibq_byte_path #(
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_word,
    input  logic [WORD_W-1:0]     fetch_word,
    input  logic                  front_wr,
    input  logic                  take_odd,
    output logic [WORD_W/2-1:0]   front_byte
);
    localparam int BYTE_W = WORD_W / 2;

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] src_word;
    logic [BYTE_W-1:0] lane [2];
    logic [BYTE_W-1:0] picked;

    assign src_word = load_word ? fetch_word : word_q;

    // lane[0] = even (upper) byte, lane[1] = odd (lower) byte
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane[g] = src_word[WORD_W-1-g*BYTE_W -: BYTE_W];
    end

    assign picked = take_odd ? lane[1] : lane[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         word_q <= '0;
        else if (load_word) word_q <= fetch_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        front_byte <= '0;
        else if (front_wr) front_byte <= picked;
    end
endmodule

// File: rtl/ibq_ctrl.sv
`timescale 1ns/1ps
module ibq_ctrl
    import ibq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dispatch_req,
    input  logic                dispatch_en,
    input  logic                read_req,
    input  logic                write_req,
    input  logic                set_byte_req,
    input  logic                set_word_req,
    input  logic                irq_pending,
    input  logic [WORD_W-1:0]   fetch_word,
    output logic                dispatch_ok,
    output logic                refill_trap,
    output logic [1:0]          trap_cause,
    output logic                front_wr,
    output logic                even_sel_n,
    output logic                odd_sel_n,
    output logic                empty_n,
    output logic [1:0]          next_occ,
    output logic [WORD_W/2-1:0] front_byte
);
    op_e    op;
    occ_e   occ_state;
    occ_e   occ_next;
    cause_e cause;
    logic   pick_even;
    logic   pick_odd;
    logic [1:0] occ_q;

    ibq_cmd_decode u_dec (
        .dispatch_req (dispatch_req),
        .dispatch_en  (dispatch_en),
        .read_req     (read_req),
        .write_req    (write_req),
        .set_byte_req (set_byte_req),
        .set_word_req (set_word_req),
        .op           (op)
    );

    ibq_occ_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .byte_hint   (set_byte_req),
        .irq_pending (irq_pending),
        .occ_q       (occ_state),
        .occ_nxt     (occ_next),
        .dispatch_ok (dispatch_ok),
        .refill_trap (refill_trap),
        .cause       (cause),
        .front_wr    (front_wr),
        .pick_even   (pick_even),
        .pick_odd    (pick_odd)
    );

    ibq_byte_path #(.WORD_W(WORD_W)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_word  (op == OP_WRITE),
        .fetch_word (fetch_word),
        .front_wr   (front_wr),
        .take_odd   (pick_odd),
        .front_byte (front_byte)
    );

    assign occ_q      = occ_state;
    assign next_occ   = occ_next;
    assign trap_cause = cause;
    assign even_sel_n = ~pick_even;
    assign odd_sel_n  = ~pick_odd;
    assign empty_n    = (occ_next != OCC_EMPTY);
endmodule

// File: rtl/ibq_ctrl_chk.sv
`timescale 1ns/1ps
module ibq_ctrl_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dispatch_req,
    input logic              read_req,
    input logic              write_req,
    input logic              set_byte_req,
    input logic              set_word_req,
    input logic              dispatch_ok,
    input logic              refill_trap,
    input logic [1:0]        trap_cause,
    input logic              front_wr,
    input logic              even_sel_n,
    input logic              odd_sel_n,
    input logic              empty_n,
    input logic [1:0]        next_occ,
    input logic [BYTE_W-1:0] front_byte,
    input logic [1:0]        occ_q
);
    logic armed;
    logic idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign idle = !(dispatch_req || read_req || write_req || set_byte_req || set_word_req);

    p_one_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dispatch_ok, refill_trap}));

    p_trap_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        refill_trap |-> !front_wr);

    p_single_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        front_wr |-> ($countones({even_sel_n, odd_sel_n}) == 1));

    p_no_select_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !front_wr |-> (even_sel_n && odd_sel_n));

    p_read_never_traps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        read_req |-> !refill_trap);

    p_state_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (occ_q == $past(next_occ)));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(idle)) |-> (occ_q == $past(occ_q)));

    p_empty_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |=> (occ_q == 2'd0));

    p_cause_only_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_cause != 2'd0) |-> refill_trap);

    p_trap_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        refill_trap |-> (trap_cause != 2'd0));

    p_front_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(front_wr)) |-> $stable(front_byte));
endmodule

bind ibq_ctrl ibq_ctrl_chk #(.BYTE_W(WORD_W/2)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dispatch_req (dispatch_req),
    .read_req     (read_req),
    .write_req    (write_req),
    .set_byte_req (set_byte_req),
    .set_word_req (set_word_req),
    .dispatch_ok  (dispatch_ok),
    .refill_trap  (refill_trap),
    .trap_cause   (trap_cause),
    .front_wr     (front_wr),
    .even_sel_n   (even_sel_n),
    .odd_sel_n    (odd_sel_n),
    .empty_n      (empty_n),
    .next_occ     (next_occ),
    .front_byte   (front_byte),
    .occ_q        (occ_q)
);

// File: tb/ibq_ctrl_bench.sv
`timescale 1ns/1ps
module ibq_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dp = 0, en = 0, rd = 0, wr = 0, sb = 0, sw = 0, irq = 0;
    logic [15:0] fw = '0;
    logic dispatch_ok, refill_trap, front_wr, even_sel_n, odd_sel_n, empty_n;
    logic [1:0] trap_cause, next_occ;
    logic [7:0] front_byte;

    always #2.5 clk = ~clk;

    ibq_ctrl u_ibq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .dispatch_req(dp), .dispatch_en(en), .read_req(rd), .write_req(wr),
        .set_byte_req(sb), .set_word_req(sw), .irq_pending(irq), .fetch_word(fw),
        .dispatch_ok(dispatch_ok), .refill_trap(refill_trap), .trap_cause(trap_cause),
        .front_wr(front_wr), .even_sel_n(even_sel_n), .odd_sel_n(odd_sel_n),
        .empty_n(empty_n), .next_occ(next_occ), .front_byte(front_byte)
    );

    typedef struct {
        string      tag;
        logic [17:0] val; // {ok,trap,cause,fwr,even_n,odd_n,empty_n,next,front}
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // reference model state
    logic [1:0]  m_occ = 2'd0;
    logic [15:0] m_word = '0;
    logic [7:0]  m_front = '0;

    task automatic step(input string tag, input logic i_dp, i_en, i_rd, i_wr,
                        i_sb, i_sw, i_irq, input logic [15:0] i_fw);
        logic ok, trap, fwr, e_n, o_n, adv, from_fetch;
        logic [1:0] cz, nx;
        logic [15:0] src;
        exp_t it;
        @(posedge clk);
        #1;
        dp = i_dp; en = i_en; rd = i_rd; wr = i_wr; sb = i_sb; sw = i_sw;
        irq = i_irq; fw = i_fw;
        ok = 0; trap = 0; fwr = 0; e_n = 1; o_n = 1; adv = 0; from_fetch = 0;
        cz = 2'd0; nx = m_occ;
        if (i_dp && i_en && !(i_rd || i_wr || i_sw)) begin
            if ((i_irq || m_occ != 2'd2) && !i_sb) begin
                trap = 1;
                cz = i_irq ? 2'd3 : (m_occ == 2'd0 ? 2'd1 : 2'd2);
            end else begin
                ok = 1; adv = 1;
            end
        end else if (i_rd && !(i_dp || i_wr || i_sw || i_sb)) begin
            adv = 1;
        end else if (i_wr && !(i_dp || i_rd)) begin
            if (m_occ == 2'd0) begin
                fwr = 1; from_fetch = 1;
                if (i_sb) begin o_n = 0; nx = 2'd1; end
                else      begin e_n = 0; nx = 2'd3; end
            end else nx = 2'd2;
        end else if (i_sw && !(i_dp || i_rd || i_wr || i_sb)) begin
            fwr = 1; e_n = 0; nx = 2'd3;
        end else if (i_sb && !(i_dp || i_rd || i_wr || i_sw)) begin
            fwr = 1; o_n = 0; nx = 2'd1;
        end
        if (adv) begin
            fwr = 1;
            if (m_occ[0]) o_n = 0; else e_n = 0;
            case (m_occ)
                2'd2: nx = 2'd3;
                2'd3: nx = 2'd1;
                default: nx = 2'd0;
            endcase
        end
        it.tag = tag;
        it.val = {ok, trap, cz, fwr, e_n, o_n, (nx != 2'd0), nx, m_front};
        q.push_back(it);
        src = from_fetch ? i_fw : m_word;
        if (fwr) m_front = (e_n == 1'b0) ? src[15:8] : src[7:0];
        if (i_wr && !(i_dp || i_rd)) m_word = i_fw;
        m_occ = nx;
    endtask

    // monitor: compares away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t it;
                logic [17:0] act;
                it = q.pop_front();
                act = {dispatch_ok, refill_trap, trap_cause, front_wr, even_sel_n,
                       odd_sel_n, empty_n, next_occ, front_byte};
                checks++;
                if (act !== it.val) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.val);
                end
            end
        end
    end

    initial begin
        #50000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        //    tag    dp en rd wr sb sw irq word
        step("R1",  0, 0, 0, 0, 0, 0, 0, 16'h0000); // reset state
        step("R13", 1, 0, 0, 0, 0, 0, 0, 16'h0000); // dispatch disabled
        step("R11", 1, 1, 0, 0, 0, 0, 0, 16'h0000); // refill, empty -> cause 1
        step("R7",  0, 0, 0, 1, 0, 0, 0, 16'hA1B2); // fill even -> WORD
        step("R8",  0, 0, 0, 1, 0, 0, 0, 16'hC3D4); // top-up -> FULL
        step("R6",  1, 1, 1, 0, 0, 0, 0, 16'h0000); // read+dispatch no-op
        step("R6",  0, 0, 1, 1, 0, 0, 0, 16'hFFFF); // read+write no-op
        step("R3",  1, 1, 0, 0, 0, 0, 1, 16'h0000); // irq -> trap cause 3 (R11)
        step("R3",  1, 1, 0, 0, 0, 1, 0, 16'h0000); // blocked by set-word
        step("R4",  1, 1, 0, 0, 0, 0, 0, 16'h0000); // good dispatch FULL->WORD even
        step("R5",  0, 0, 1, 0, 0, 0, 0, 16'h0000); // read WORD->ONE odd
        step("R11", 1, 1, 0, 0, 0, 0, 0, 16'h0000); // refill, not empty -> cause 2
        step("R3",  1, 1, 0, 0, 1, 0, 0, 16'h0000); // byte hint: dispatch ONE->EMPTY
        step("R4",  0, 0, 1, 0, 0, 0, 0, 16'h0000); // EMPTY stays EMPTY, even
        step("R7",  0, 0, 0, 1, 1, 0, 0, 16'h5E6F); // fill odd -> ONE
        step("R2",  0, 0, 0, 0, 0, 0, 0, 16'h0000); // hold ONE
        step("R9",  0, 0, 0, 0, 0, 1, 0, 16'h0000); // set-word -> WORD, even
        step("R9",  0, 0, 0, 0, 1, 0, 0, 16'h0000); // set-byte -> ONE, odd
        step("R8",  0, 0, 0, 1, 0, 0, 0, 16'h1122); // top-up from ONE -> FULL
        step("R9",  0, 0, 0, 0, 1, 1, 0, 16'h0000); // both aligns: no-op
        step("R4",  0, 0, 1, 0, 0, 0, 0, 16'h0000); // read FULL->WORD, front 11
        step("R10", 0, 0, 1, 0, 0, 0, 0, 16'h0000); // WORD->ONE, front 22
        step("R10", 0, 0, 1, 0, 0, 0, 0, 16'h0000); // ONE->EMPTY, empty_n low
        step("R12", 0, 0, 0, 0, 0, 0, 0, 16'h0000); // front holds
        @(posedge clk);
        @(posedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule